// File: doc/BRIEF.md
# Serial Bit Stuffer and Destuffer with Zero-Run Breaking

This block is a matched pair of serial bit units for a bit-oriented link carried on an NRZ bus. The transmit unit takes user bits over a valid/ready handshake. It emits one line bit in each cycle its bit enable is high and it has something to send. It adds a 0 after every run of five 1s. When the zero-run option is on, it also adds a 1 after every run of seven 0s, so that a clock recovery circuit on the far side always sees edges. The receive unit watches the line, deletes exactly those added bits, and hands the original bits on with a valid strobe. The added bits never reach the user data path.

Both units have a bypass input. While flags or abort patterns are being sent, bypass passes bits through unchanged and keeps both run counters at zero. The receiver raises an error strobe for each 1 that extends a run of 1s beyond five while bypass is low. Such a run cannot occur in stuffed data. The zero-run option must be set the same way at both ends of the link.

Top module: `bstf_codec_pair`

## Requirements
- R1: Outside bypass, the transmitter emits a 0 line bit directly after every five consecutive 1 line bits.
- R2: With `oin_en` = 1 and outside bypass, the transmitter emits a 1 line bit directly after every seven consecutive 0 line bits. With `oin_en` = 0, runs of 0s of any length pass with no added bit.
- R3: The transmitter emits a line bit only in a cycle in which `tx_bit_en` was high. `tx_ready` is low in a cycle that emits an added bit and in any cycle with `tx_bit_en` low. An added bit is sent even when `tx_valid` is low.
- R4: Outside bypass, the receiver deletes a 0 that follows exactly five consecutive 1s.
- R5: With `oin_en` = 1 and outside bypass, the receiver deletes a 1 that follows exactly seven consecutive 0s. With `oin_en` = 0, it delivers that 1.
- R6: With transmitter output looped to the receiver input and both ends set alike, the sequence of bits on `rx_out_bit` equals the sequence accepted at `tx_bit`, and no bit is lost.
- R7: An added bit counts as the first bit of a new run of its own value, and it clears the count of the opposite value.
- R8: While bypass is high, bits pass through unchanged in both units and no bit is added or deleted. Bypass clears both run counts, so counting restarts from zero when bypass ends.
- R9: Outside bypass, `rx_err` pulses one cycle after each received 1 that is the sixth or later consecutive 1. It never pulses on stuffed traffic.
- R10: After reset, `tx_line_vld`, `rx_out_vld` and `rx_err` are low, and both run counts are zero.
- R11: A bit accepted by the transmitter appears on `tx_line_bit` in the next cycle. A received bit that is kept appears on `rx_out_bit` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oin_en | input | 1 | Enables the one-after-seven-zeros rule |
| tx_bit_en | input | 1 | Transmit bit-time enable |
| tx_bypass | input | 1 | Transmit pass-through, clears run counts |
| tx_valid | input | 1 | User bit offered |
| tx_bit | input | 1 | User bit value |
| tx_ready | output | 1 | User bit taken this cycle when valid |
| tx_line_vld | output | 1 | Line bit present |
| tx_line_bit | output | 1 | Line bit value |
| rx_bypass | input | 1 | Receive pass-through, clears run counts |
| rx_line_vld | input | 1 | Received line bit present |
| rx_line_bit | input | 1 | Received line bit value |
| rx_out_vld | output | 1 | Recovered user bit present |
| rx_out_bit | output | 1 | Recovered user bit value |
| rx_err | output | 1 | Run of 1s longer than five seen |

## Verification
A wrong run count in the transmitter shows on the line within one bit time. An added bit then appears one bit early or late, or not at all, and a data bit goes out while `tx_ready` should have been low. A wrong count in the receiver shows in the next cycle. A kept bit goes missing, or an added bit leaks onto `rx_out_bit`, so the recovered sequence shifts against the sent one and every later comparison fails. Sweeping every 10-bit pattern back to back, with the option both off and on and with a gapped bit enable, drives every run length across pattern borders into both counters.

// File: rtl/bstf_pkg.sv
package bstf_pkg;

    // What the transmitter puts on the line in a given cycle
    typedef enum logic [1:0] {
        EMIT_NONE  = 2'd0,
        EMIT_DATA  = 2'd1,
        EMIT_ADD0  = 2'd2,
        EMIT_ADD1  = 2'd3
    } emit_e;

    function automatic int run_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bstf_run_tracker.sv
module bstf_run_tracker #(
    parameter int ONES_RUN  = 5,
    parameter int ZEROS_RUN = 7,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          bit_i,
    input  logic          clear,
    output logic [CW-1:0] ones_o,
    output logic [CW-1:0] zeros_o
);
    localparam logic [CW-1:0] ONES_SAT  = CW'(ONES_RUN + 1);
    localparam logic [CW-1:0] ZEROS_SAT = CW'(ZEROS_RUN + 1);

    typedef struct packed {
        logic [CW-1:0] ones;
        logic [CW-1:0] zeros;
    } run_t;

    run_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.ones  = '0;
            st_d.zeros = '0;
        end else if (step) begin
            if (bit_i) begin
                st_d.ones  = (st_q.ones == ONES_SAT) ? st_q.ones : st_q.ones + 1'b1;
                st_d.zeros = '0;
            end else begin
                st_d.zeros = (st_q.zeros == ZEROS_SAT) ? st_q.zeros : st_q.zeros + 1'b1;
                st_d.ones  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ones_o  = st_q.ones;
    assign zeros_o = st_q.zeros;

    // R7: any counted 1 (added or not) restarts the 0 run and extends the 1 run
    a_r7_one_restarts_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        step && !clear && bit_i |=> (zeros_o == '0) && (ones_o != '0));
    a_r7_zero_restarts_ones: assert property (@(posedge clk) disable iff (!rst_n)
        step && !clear && !bit_i |=> (ones_o == '0) && (zeros_o != '0));
    // R8: bypass leaves both counts at zero
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ones_o == '0) && (zeros_o == '0));
endmodule

// File: rtl/bstf_tx.sv
module bstf_tx
    import bstf_pkg::*;
#(
    parameter int ONES_RUN  = 5,
    parameter int ZEROS_RUN = 7,
    parameter int CW        = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oin_en,
    input  logic bit_en,
    input  logic bypass,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic line_vld,
    output logic line_bit
);
    localparam logic [CW-1:0] ONES_LIM  = CW'(ONES_RUN);
    localparam logic [CW-1:0] ZEROS_LIM = CW'(ZEROS_RUN);

    typedef struct packed {
        logic vld;
        logic bitv;
    } line_t;

    line_t         ln_d, ln_q;
    logic [CW-1:0] ones_q, zeros_q;
    logic          need0, need1, pending;
    emit_e         sel;
    logic          emit_bit;

    always_comb begin
        need0    = (ones_q == ONES_LIM);
        need1    = oin_en && (zeros_q == ZEROS_LIM);
        pending  = !bypass && (need0 || need1);
        in_ready = bit_en && !pending;

        if (!bit_en)       sel = EMIT_NONE;
        else if (pending)  sel = need0 ? EMIT_ADD0 : EMIT_ADD1;
        else if (in_valid) sel = EMIT_DATA;
        else               sel = EMIT_NONE;

        case (sel)
            EMIT_ADD0: emit_bit = 1'b0;
            EMIT_ADD1: emit_bit = 1'b1;
            EMIT_DATA: emit_bit = in_bit;
            default:   emit_bit = ln_q.bitv;
        endcase

        ln_d.vld  = (sel != EMIT_NONE);
        ln_d.bitv = emit_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    bstf_run_tracker #(
        .ONES_RUN (ONES_RUN),
        .ZEROS_RUN(ZEROS_RUN),
        .CW       (CW)
    ) u_runs (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (sel != EMIT_NONE),
        .bit_i  (emit_bit),
        .clear  (bypass),
        .ones_o (ones_q),
        .zeros_o(zeros_q)
    );

    assign line_vld = ln_q.vld;
    assign line_bit = ln_q.bitv;

    // R1: a full 1 run forces a 0 onto the line next cycle
    a_r1_zero_after_ones: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && !bypass && ones_q == ONES_LIM |=> line_vld && !line_bit);
    // R1: the 1 run never grows past its limit outside bypass
    a_r1_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass && !$past(bypass) |-> ones_q <= ONES_LIM);
    // R2: a full 0 run forces a 1 when the option is on
    a_r2_one_after_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && !bypass && oin_en && zeros_q == ZEROS_LIM && ones_q != ONES_LIM
        |=> line_vld && line_bit);
    // R3: no line bit without a bit-time enable
    a_r3_no_emit_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !line_vld);
    // R11: an accepted bit shows up unchanged one cycle later
    a_r11_accept_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> line_vld && (line_bit == $past(in_bit)));
endmodule

// File: rtl/bstf_rx.sv
module bstf_rx #(
    parameter int ONES_RUN  = 5,
    parameter int ZEROS_RUN = 7,
    parameter int CW        = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oin_en,
    input  logic bypass,
    input  logic line_vld,
    input  logic line_bit,
    output logic out_vld,
    output logic out_bit,
    output logic err
);
    localparam logic [CW-1:0] ONES_LIM  = CW'(ONES_RUN);
    localparam logic [CW-1:0] ZEROS_LIM = CW'(ZEROS_RUN);

    typedef struct packed {
        logic vld;
        logic bitv;
        logic err;
    } rxo_t;

    rxo_t          o_d, o_q;
    logic [CW-1:0] ones_q, zeros_q;
    logic          drop0, drop1, drop;

    always_comb begin
        drop0 = !line_bit && (ones_q == ONES_LIM);
        drop1 = oin_en && line_bit && (zeros_q == ZEROS_LIM);
        drop  = line_vld && !bypass && (drop0 || drop1);

        o_d.vld  = line_vld && !drop;
        o_d.bitv = line_vld ? line_bit : o_q.bitv;
        o_d.err  = line_vld && !bypass && line_bit && (ones_q >= ONES_LIM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    bstf_run_tracker #(
        .ONES_RUN (ONES_RUN),
        .ZEROS_RUN(ZEROS_RUN),
        .CW       (CW)
    ) u_runs (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (line_vld),
        .bit_i  (line_bit),
        .clear  (bypass),
        .ones_o (ones_q),
        .zeros_o(zeros_q)
    );

    assign out_vld = o_q.vld;
    assign out_bit = o_q.bitv;
    assign err     = o_q.err;

    // R4: the 0 after a full 1 run is not delivered
    a_r4_drop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        line_vld && !bypass && !line_bit && ones_q == ONES_LIM |=> !out_vld);
    // R5: the 1 after a full 0 run is not delivered when the option is on
    a_r5_drop_one: assert property (@(posedge clk) disable iff (!rst_n)
        line_vld && !bypass && oin_en && line_bit && zeros_q == ZEROS_LIM |=> !out_vld);
    // R8: in bypass every line bit is delivered unchanged
    a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        line_vld && bypass |=> out_vld && (out_bit == $past(line_bit)) && !err);
    // R9: an error strobe always follows a received 1
    a_r9_err_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(line_vld && line_bit));
    // R11: delivered bits come one cycle after a received bit
    a_r11_rx_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(line_vld));
endmodule

// File: rtl/bstf_codec_pair.sv
module bstf_codec_pair
    import bstf_pkg::*;
#(
    parameter int ONES_RUN  = 5,
    parameter int ZEROS_RUN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oin_en,
    input  logic tx_bit_en,
    input  logic tx_bypass,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic tx_ready,
    output logic tx_line_vld,
    output logic tx_line_bit,
    input  logic rx_bypass,
    input  logic rx_line_vld,
    input  logic rx_line_bit,
    output logic rx_out_vld,
    output logic rx_out_bit,
    output logic rx_err
);
    localparam int RUN_TOP = run_max(ONES_RUN, ZEROS_RUN);
    localparam int CW      = $clog2(RUN_TOP + 2);

    bstf_tx #(
        .ONES_RUN (ONES_RUN),
        .ZEROS_RUN(ZEROS_RUN),
        .CW       (CW)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .oin_en  (oin_en),
        .bit_en  (tx_bit_en),
        .bypass  (tx_bypass),
        .in_valid(tx_valid),
        .in_bit  (tx_bit),
        .in_ready(tx_ready),
        .line_vld(tx_line_vld),
        .line_bit(tx_line_bit)
    );

    bstf_rx #(
        .ONES_RUN (ONES_RUN),
        .ZEROS_RUN(ZEROS_RUN),
        .CW       (CW)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .oin_en  (oin_en),
        .bypass  (rx_bypass),
        .line_vld(rx_line_vld),
        .line_bit(rx_line_bit),
        .out_vld (rx_out_vld),
        .out_bit (rx_out_bit),
        .err     (rx_err)
    );

    // R10: nothing is emitted in the first cycle after reset
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !tx_line_vld && !rx_out_vld && !rx_err);
endmodule

// File: tb/bstf_codec_pair_bench.sv
module bstf_codec_pair_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oin_en = 1'b0;
    logic tx_bit_en = 1'b1;
    logic tx_bypass = 1'b0;
    logic tx_valid = 1'b0;
    logic tx_bit = 1'b0;
    logic tx_ready, tx_line_vld, tx_line_bit;
    logic rx_bypass = 1'b0;
    logic rx_out_vld, rx_out_bit, rx_err;
    logic inj = 1'b0, inj_vld = 1'b0, inj_b = 1'b0;
    logic gap_mode = 1'b0;
    logic done = 1'b0;

    int checks = 0, errors = 0;
    bit txq[$];
    bit rxq[$];
    int m_ones = 0, m_zeros = 0;
    logic pv_ready = 1'b0, pv_valid = 1'b0, pv_en = 1'b0, pv_byp = 1'b0;
    int inj_cnt = 0, inj_sum = 0, inj_err = 0;

    always #10 clk = ~clk;   // 50 MHz

    bstf_codec_pair u_bstf_codec_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .oin_en     (oin_en),
        .tx_bit_en  (tx_bit_en),
        .tx_bypass  (tx_bypass),
        .tx_valid   (tx_valid),
        .tx_bit     (tx_bit),
        .tx_ready   (tx_ready),
        .tx_line_vld(tx_line_vld),
        .tx_line_bit(tx_line_bit),
        .rx_bypass  (rx_bypass),
        .rx_line_vld(inj ? inj_vld : tx_line_vld),
        .rx_line_bit(inj ? inj_b : tx_line_bit),
        .rx_out_vld (rx_out_vld),
        .rx_out_bit (rx_out_bit),
        .rx_err     (rx_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // bit-time enable: steady or every other cycle
    always @(negedge clk) tx_bit_en <= gap_mode ? ~tx_bit_en : 1'b1;

    // line and output monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            m_ones = 0; m_zeros = 0;
        end else begin
            if (tx_line_vld) begin
                bit e; bit added;
                check(pv_en, "R3 line bit without enable", 1, 0);
                added = 1'b0;
                if (!pv_byp && m_ones == 5) begin e = 1'b0; added = 1'b1; end        // R1
                else if (!pv_byp && oin_en && m_zeros == 7) begin e = 1'b1; added = 1'b1; end // R2
                else if (txq.size() > 0) e = txq.pop_front();
                else begin e = ~tx_line_bit; end
                check(tx_line_bit == e, added ? "R1/R2 added bit" : "R11 data bit", tx_line_bit, e);
                if (added) check(!pv_ready, "R3 ready during added bit", pv_ready, 0);
                else       check(pv_valid && pv_ready, "R11 data without handshake", pv_ready, 1);
                // R7: added bits count in the runs; R8: bypass clears
                if (pv_byp) begin m_ones = 0; m_zeros = 0; end
                else if (tx_line_bit) begin m_ones++; m_zeros = 0; end
                else begin m_zeros++; m_ones = 0; end
            end
            if (inj) begin
                inj_cnt += rx_out_vld ? 1 : 0;
                inj_sum += (rx_out_vld && rx_out_bit) ? 1 : 0;
                inj_err += rx_err ? 1 : 0;
            end else begin
                if (rx_out_vld) begin
                    bit e2;
                    e2 = (rxq.size() > 0) ? rxq.pop_front() : ~rx_out_bit;
                    check(rx_out_bit == e2, "R6 recovered bit", rx_out_bit, e2);
                end
                if (rx_err) check(1'b0, "R9 error on stuffed traffic", 1, 0);
            end
        end
        #3;
        pv_ready = tx_ready; pv_valid = tx_valid; pv_en = tx_bit_en; pv_byp = tx_bypass;
    end

    task automatic send(input bit b);
        tx_valid = 1'b1; tx_bit = b;
        #1;
        while (!tx_ready) begin @(negedge clk); #2; end
        txq.push_back(b); rxq.push_back(b);
        @(negedge clk); #1;
        tx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(1);
    endtask

    task automatic drain(input string tag);
        idle(8);
        check(txq.size() == 0 && rxq.size() == 0, tag, txq.size() + rxq.size(), 0);
    endtask

    task automatic inject(input bit b);
        inj_vld = 1'b1; inj_b = b; @(negedge clk); #1; inj_vld = 1'b0;
    endtask

    task automatic inj_run(input int pat, input int len, input bit oin,
                           input int e_cnt, input int e_sum, input int e_err, input string tag);
        do_reset();
        oin_en = oin; inj = 1'b1;
        inj_cnt = 0; inj_sum = 0; inj_err = 0;
        for (int i = len - 1; i >= 0; i--) inject(pat[i]);
        idle(3);
        check(inj_cnt == e_cnt, {tag, " count"}, inj_cnt, e_cnt);
        check(inj_sum == e_sum, {tag, " ones"}, inj_sum, e_sum);
        check(inj_err == e_err, {tag, " errors"}, inj_err, e_err);
        inj = 1'b0;
    endtask

    initial begin
        do_reset();
        // R10: reset state
        check(!tx_line_vld, "R10 line valid", tx_line_vld, 0);
        check(!rx_out_vld, "R10 out valid", rx_out_vld, 0);
        check(!rx_err, "R10 err", rx_err, 0);
        check(tx_ready, "R10 ready with zero counts", tx_ready, 1);

        // R1 R2 R6 R7: every 10-bit pattern back to back, option off then on
        for (int o = 0; o < 2; o++) begin
            oin_en = o[0];
            do_reset();
            for (int p = 0; p < 1024; p++)
                for (int i = 9; i >= 0; i--) send(p[i]);
            for (int i = 0; i < 20; i++) send(1'b0);   // long 0 run: R2 off case
            for (int i = 0; i < 13; i++) send(1'b1);
            drain("R6 sweep queues empty");
        end

        // R3: gapped bit enable with the option on
        gap_mode = 1'b1;
        for (int p = 0; p < 256; p++)
            for (int i = 7; i >= 0; i--) send(p[i]);
        drain("R3 gapped queues empty");
        gap_mode = 1'b0; idle(2);

        // R8: bypass passes runs unchanged and clears counts
        for (int i = 0; i < 4; i++) send(1'b1);
        idle(4);
        tx_bypass = 1'b1; rx_bypass = 1'b1; idle(2);
        for (int i = 0; i < 8; i++) send(1'b1);
        for (int i = 0; i < 9; i++) send(1'b0);
        idle(4);
        tx_bypass = 1'b0; rx_bypass = 1'b0; idle(2);
        for (int i = 0; i < 4; i++) send(1'b1);
        send(1'b0);
        for (int i = 0; i < 6; i++) send(1'b1);
        drain("R8 bypass queues empty");

        // R4 R9: direct receiver stimulus
        inj_run('b1111101, 7, 1'b0, 6, 6, 0, "R4 stuffed zero removed");
        inj_run('b11111110, 8, 1'b0, 8, 7, 2, "R9 six and seven ones");
        // R5: one after seven zeros
        inj_run('b000000010, 9, 1'b1, 8, 0, 0, "R5 added one removed");
        inj_run('b000000010, 9, 1'b0, 9, 1, 0, "R5 option off keeps one");
        // R8: receiver bypass keeps everything
        rx_bypass = 1'b1;
        inj_run('b1111101, 7, 1'b1, 7, 6, 0, "R8 rx bypass");
        rx_bypass = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule